// File: doc/BRIEF.md
# Synchronous Dual-Port Byte-Lane SRAM

This block is a true dual-port static memory with two independent access ports, A and B. Both ports are sampled on the rising edge of one shared clock. Each port has a two-signal chip select, a read/write select, one active-low select per byte lane, an asynchronous output enable and a static output-mode pin. The word is 18 bits wide and split into two 9-bit lanes. Address, write data and all synchronous controls are registered at the clock edge before they act.

Read data leaves each port in one of two ways. In flow-through mode the word arrives in the same cycle as the address. In pipelined mode it arrives one cycle later. The tri-state bus is modelled as a data vector plus one drive-enable per lane. A lane that is not driven reads as zero. In pipelined mode the chip-select path has two register stages while the lane selects keep one, so a deselect reaches the outputs one cycle late.

The depth is a parameter. It defaults to 1K words and is raised to 8K words (13 address bits) in the target build. Both ports may touch the same word in the same cycle. Read-during-write and write-write collisions follow fixed rules.

Top module: `dual_port_sram`

## Requirements
- R1: A port is selected only when its `cs0_n` is 0 and its `cs1` is 1 at the clock edge. Any other combination leaves both lanes of that port undriven and writes nothing.
- R2: A selected write (`rnw` = 0) stores only the lanes whose `lane_n` bit is 0. Lane 0 is bits 8..0 and lane 1 is bits 17..9. The other lanes keep their contents.
- R3: A lane is driven only when `oe_n` is 0 and the registered lane select for that lane is active. `oe_n` takes effect with no clock edge. An undriven lane reads as zero.
- R4: With `pipe` = 0, a selected read registered at an edge drives the addressed word from just after that edge until the next edge.
- R5: With `pipe` = 1, a selected read registered at an edge drives the addressed word in the following cycle, not in its own cycle.
- R6: With `pipe` = 1, a read keeps driving for one cycle after a deselecting edge. With `pipe` = 0, the outputs go quiet in the cycle of the deselect itself.
- R7: The lane selects pass through one register stage in both modes. In pipelined mode, the lanes that drive are the ones chosen at the most recent edge.
- R8: While a port has a selected write registered, it drives neither lane. This holds even when a pipelined read from the previous cycle is pending.
- R9: When one port writes a word and the other port reads that word at the same edge, the read returns the old contents. The new value is returned from the next read onward.
- R10: When both ports write the same lane of the same word at the same edge, port A's data is stored.
- R11: After reset, and until a read is issued, neither port drives any lane.
- R12: Both ports may read the same word at the same edge, and both return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control stages |
| a_cs0_n | input | 1 | Port A chip select, active low |
| a_cs1 | input | 1 | Port A chip select, active high |
| a_rnw | input | 1 | Port A: 1 = read, 0 = write |
| a_lane_n | input | 2 | Port A lane selects, active low, bit 0 = lower lane |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A static mode: 0 = flow-through, 1 = pipelined |
| a_addr | input | 10 | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, zero on undriven lanes |
| a_drive | output | 2 | Port A per-lane drive enable |
| b_cs0_n | input | 1 | Port B chip select, active low |
| b_cs1 | input | 1 | Port B chip select, active high |
| b_rnw | input | 1 | Port B: 1 = read, 0 = write |
| b_lane_n | input | 2 | Port B lane selects, active low, bit 0 = lower lane |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B static mode: 0 = flow-through, 1 = pipelined |
| b_addr | input | 10 | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, zero on undriven lanes |
| b_drive | output | 2 | Port B per-lane drive enable |

## Verification
A wrong chip-select stage shows up as a drive-enable that is high or low one cycle off. This is seen in the cycle right after the deselecting edge in pipelined mode, and in the same cycle in flow-through mode. A lane-select register that is wrong, or wired to the wrong stage, shows up as the wrong lane driven in the very next cycle. Faults in the storage or in the write ordering, such as a lost lane mask, the wrong collision winner or a read that bypasses a same-edge write, stay hidden until a later read of that word. The directed tests therefore always read a word back, and where possible through the other port.

// File: rtl/dpsram_pkg.sv
// Package: shared defaults and the output-mode encoding for the dual-port SRAM.
// Assumes: every module takes its widths from parameters whose defaults come from here.
package dpsram_pkg;
    localparam int DEF_ADDR_W = 10;   // 1K words by default; 13 gives 8K words
    localparam int DEF_LANE_W = 9;    // bits per byte lane
    localparam int DEF_LANES  = 2;    // lanes per word

    // Encoding of the static per-port mode pin
    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;
endpackage

// File: rtl/dpsram_port_in.sv
// Module: input register stage of one port.
// What it does: registers the select decode, read/write select, lane selects,
//   address and write data at the clock edge. It keeps a second stage of the
//   select and read/write bits for pipelined output.
// Assumes: synchronous active-low reset clears only the control stages.
//   Address and data registers carry no reset.
module dpsram_port_in #(
    parameter int ADDR_W = dpsram_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpsram_pkg::DEF_LANE_W,
    parameter int LANES  = dpsram_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              rnw,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              sel_q,
    output logic              sel_q2,
    output logic              rnw_q,
    output logic              rnw_q2,
    output logic [LANES-1:0]  lane_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata_q,
    output logic [LANES-1:0]  wr_lane
);

    // Control stages: one stage for the lane selects, two for select and read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            sel_q2 <= 1'b0;
            rnw_q  <= 1'b1;
            rnw_q2 <= 1'b1;
            lane_q <= '0;
        end else begin
            sel_q  <= ~cs0_n & cs1;
            sel_q2 <= sel_q;
            rnw_q  <= rnw;
            rnw_q2 <= rnw_q;
            lane_q <= ~lane_n;
        end
    end

    // Address and write-data capture, no reset needed
    always_ff @(posedge clk) begin
        addr_q  <= addr;
        wdata_q <= wdata;
    end

    // Per-lane write strobe toward the array
    always_comb begin
        wr_lane = lane_q & {LANES{sel_q & ~rnw_q}};
    end

endmodule

// File: rtl/dpsram_array.sv
// Module: lane-sliced storage shared by both ports.
// What it does: holds one memory per byte lane. Each lane memory is written in
//   a single process, with port A applied last so that A wins a same-lane
//   collision. It gives an asynchronous read of each port's registered address
//   and a one-cycle read-hold register for pipelined output.
// Assumes: both ports share one clock. A read at the same edge as a write sees
//   the old contents.
module dpsram_array #(
    parameter int ADDR_W = dpsram_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpsram_pkg::DEF_LANE_W,
    parameter int LANES  = dpsram_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  a_wr_lane,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    input  logic [LANES-1:0]  b_wr_lane,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] a_rd_now,
    output logic [WORD_W-1:0] b_rd_now,
    output logic [WORD_W-1:0] a_rd_hold,
    output logic [WORD_W-1:0] b_rd_hold
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_lane [DEPTH];

        // Lane write: B first, then A, so A overrides on a same-word collision
        always_ff @(posedge clk) begin
            if (b_wr_lane[l]) mem_lane[b_addr] <= b_wdata[l*LANE_W +: LANE_W];
            if (a_wr_lane[l]) mem_lane[a_addr] <= a_wdata[l*LANE_W +: LANE_W];
        end

        // Asynchronous read of each port's registered address
        always_comb begin
            a_rd_now[l*LANE_W +: LANE_W] = mem_lane[a_addr];
            b_rd_now[l*LANE_W +: LANE_W] = mem_lane[b_addr];
        end

        // Read hold for pipelined output, sampled before this edge's write lands
        always_ff @(posedge clk) begin
            a_rd_hold[l*LANE_W +: LANE_W] <= mem_lane[a_addr];
            b_rd_hold[l*LANE_W +: LANE_W] <= mem_lane[b_addr];
        end

        AST_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (a_wr_lane[l] && b_wr_lane[l] && a_addr == b_addr)
            |=> (mem_lane[$past(a_addr)] == $past(a_wdata[l*LANE_W +: LANE_W]))); // R10

        AST_LANE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_wr_lane[l] && !b_wr_lane[l])
            |=> (mem_lane[$past(a_addr)] == $past(a_rd_now[l*LANE_W +: LANE_W]))); // R2
    end

endmodule

// File: rtl/dpsram_port_out.sv
// Module: output stage of one port.
// What it does: picks the flow-through or the held read word according to the
//   static mode pin. It forms the per-lane drive enables from the select stage
//   that matches the mode, the single-stage lane selects, the write-in-progress
//   condition and the asynchronous output enable. Lanes that are not driven
//   read as zero.
// Assumes: the mode pin is only changed while the port is idle.
module dpsram_port_out #(
    parameter int LANE_W = dpsram_pkg::DEF_LANE_W,
    parameter int LANES  = dpsram_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic              sel_q,
    input  logic              sel_q2,
    input  logic              rnw_q,
    input  logic              rnw_q2,
    input  logic [LANES-1:0]  lane_q,
    input  logic [WORD_W-1:0] rd_now,
    input  logic [WORD_W-1:0] rd_hold,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  drive
);

    logic              wr_busy;
    logic              src_ok;
    logic [WORD_W-1:0] src_word;

    // Source selection by output mode
    always_comb begin
        wr_busy = sel_q & ~rnw_q;
        if (dpsram_pkg::out_mode_e'(pipe) == dpsram_pkg::OUT_PIPE) begin
            src_ok   = sel_q2 & rnw_q2 & ~wr_busy;
            src_word = rd_hold;
        end else begin
            src_ok   = sel_q & rnw_q;
            src_word = rd_now;
        end
    end

    // Per-lane drive enable and zero masking of undriven lanes
    for (genvar l = 0; l < LANES; l++) begin : g_drv
        always_comb begin
            drive[l] = src_ok & lane_q[l] & ~oe_n;
            rdata[l*LANE_W +: LANE_W] = drive[l] ? src_word[l*LANE_W +: LANE_W] : '0;
        end

        AST_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            drive[l] |-> lane_q[l]); // R7
    end

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !rnw_q) |-> (drive == '0)); // R8

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (drive == '0)); // R3

    AST_FLOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && !sel_q) |-> (drive == '0)); // R1

    AST_PIPE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && !sel_q2) |-> (drive == '0)); // R6

endmodule

// File: rtl/dual_port_sram.sv
// Module: top of the dual-port byte-lane SRAM.
// What it does: ties two input stages, the shared lane-sliced array and two
//   output stages together. Both ports run on one clock.
// Assumes: synchronous active-low reset; mode pins are static during traffic.
module dual_port_sram #(
    parameter int ADDR_W = dpsram_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpsram_pkg::DEF_LANE_W,
    parameter int LANES  = dpsram_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs0_n,
    input  logic              a_cs1,
    input  logic              a_rnw,
    input  logic [LANES-1:0]  a_lane_n,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_rdata,
    output logic [LANES-1:0]  a_drive,
    input  logic              b_cs0_n,
    input  logic              b_cs1,
    input  logic              b_rnw,
    input  logic [LANES-1:0]  b_lane_n,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_rdata,
    output logic [LANES-1:0]  b_drive
);

    logic              a_sel_q, a_sel_q2, a_rnw_q, a_rnw_q2;
    logic              b_sel_q, b_sel_q2, b_rnw_q, b_rnw_q2;
    logic [LANES-1:0]  a_lane_q, b_lane_q, a_wr_lane, b_wr_lane;
    logic [ADDR_W-1:0] a_addr_q, b_addr_q;
    logic [WORD_W-1:0] a_wdata_q, b_wdata_q;
    logic [WORD_W-1:0] a_rd_now, b_rd_now, a_rd_hold, b_rd_hold;

    dpsram_port_in #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_in_a (
        .clk(clk), .rst_n(rst_n), .cs0_n(a_cs0_n), .cs1(a_cs1), .rnw(a_rnw),
        .lane_n(a_lane_n), .addr(a_addr), .wdata(a_wdata),
        .sel_q(a_sel_q), .sel_q2(a_sel_q2), .rnw_q(a_rnw_q), .rnw_q2(a_rnw_q2),
        .lane_q(a_lane_q), .addr_q(a_addr_q), .wdata_q(a_wdata_q), .wr_lane(a_wr_lane)
    );

    dpsram_port_in #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_in_b (
        .clk(clk), .rst_n(rst_n), .cs0_n(b_cs0_n), .cs1(b_cs1), .rnw(b_rnw),
        .lane_n(b_lane_n), .addr(b_addr), .wdata(b_wdata),
        .sel_q(b_sel_q), .sel_q2(b_sel_q2), .rnw_q(b_rnw_q), .rnw_q2(b_rnw_q2),
        .lane_q(b_lane_q), .addr_q(b_addr_q), .wdata_q(b_wdata_q), .wr_lane(b_wr_lane)
    );

    dpsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .a_wr_lane(a_wr_lane), .a_addr(a_addr_q), .a_wdata(a_wdata_q),
        .b_wr_lane(b_wr_lane), .b_addr(b_addr_q), .b_wdata(b_wdata_q),
        .a_rd_now(a_rd_now), .b_rd_now(b_rd_now),
        .a_rd_hold(a_rd_hold), .b_rd_hold(b_rd_hold)
    );

    dpsram_port_out #(.LANE_W(LANE_W), .LANES(LANES)) u_out_a (
        .clk(clk), .rst_n(rst_n), .oe_n(a_oe_n), .pipe(a_pipe),
        .sel_q(a_sel_q), .sel_q2(a_sel_q2), .rnw_q(a_rnw_q), .rnw_q2(a_rnw_q2),
        .lane_q(a_lane_q), .rd_now(a_rd_now), .rd_hold(a_rd_hold),
        .rdata(a_rdata), .drive(a_drive)
    );

    dpsram_port_out #(.LANE_W(LANE_W), .LANES(LANES)) u_out_b (
        .clk(clk), .rst_n(rst_n), .oe_n(b_oe_n), .pipe(b_pipe),
        .sel_q(b_sel_q), .sel_q2(b_sel_q2), .rnw_q(b_rnw_q), .rnw_q2(b_rnw_q2),
        .lane_q(b_lane_q), .rd_now(b_rd_now), .rd_hold(b_rd_hold),
        .rdata(b_rdata), .drive(b_drive)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (a_drive == '0 && b_drive == '0)); // R11

endmodule

// File: tb/dual_port_sram_test.sv
`timescale 1ns/1ps
module dual_port_sram_test;

    localparam int AW = 10;
    localparam int WW = 18;
    localparam logic [WW-1:0] LO = 18'h001FF;
    localparam logic [WW-1:0] V5 = 18'h2A5A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_cs0_n, a_cs1, a_rnw, a_oe_n, a_pipe;
    logic b_cs0_n, b_cs1, b_rnw, b_oe_n, b_pipe;
    logic [1:0] a_lane_n, b_lane_n, a_drive, b_drive;
    logic [AW-1:0] a_addr, b_addr;
    logic [WW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dual_port_sram uut (
        .clk(clk), .rst_n(rst_n),
        .a_cs0_n(a_cs0_n), .a_cs1(a_cs1), .a_rnw(a_rnw), .a_lane_n(a_lane_n),
        .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_drive(a_drive),
        .b_cs0_n(b_cs0_n), .b_cs1(b_cs1), .b_rnw(b_rnw), .b_lane_n(b_lane_n),
        .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_drive(b_drive)
    );

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_a(input logic cs0n, input logic c1, input logic rw,
                         input logic [1:0] ln, input logic [AW-1:0] ad, input logic [WW-1:0] wd);
        a_cs0_n = cs0n; a_cs1 = c1; a_rnw = rw; a_lane_n = ln; a_addr = ad; a_wdata = wd;
    endtask

    task automatic set_b(input logic cs0n, input logic c1, input logic rw,
                         input logic [1:0] ln, input logic [AW-1:0] ad, input logic [WW-1:0] wd);
        b_cs0_n = cs0n; b_cs1 = c1; b_rnw = rw; b_lane_n = ln; b_addr = ad; b_wdata = wd;
    endtask

    task automatic idle_both();
        set_a(1'b1, 1'b1, 1'b1, 2'b00, '0, '0);
        set_b(1'b1, 1'b1, 1'b1, 2'b00, '0, '0);
    endtask

    // Reset leaves both ports quiet (R11)
    task automatic t_reset();
        idle_both();
        a_oe_n = 1'b0; b_oe_n = 1'b0; a_pipe = 1'b0; b_pipe = 1'b0;
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R11 a_drive after reset", {16'h0, a_drive}, '0);
        check("R11 b_drive after reset", {16'h0, b_drive}, '0);
    endtask

    // Flow-through write then read (R4, R8)
    task automatic t_flow_basic();
        set_a(1'b0, 1'b1, 1'b0, 2'b00, 10'd5, V5);
        tick();
        check("R8 no drive in write cycle", {16'h0, a_drive}, '0);
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R4 flow drive", {16'h0, a_drive}, 18'd3);
        check("R4 flow data", a_rdata, V5);
        idle_both();
        tick();
    endtask

    // Lane-masked writes, read back through port B (R2)
    task automatic t_lanes();
        set_a(1'b0, 1'b1, 1'b0, 2'b00, 10'd6, 18'h3FFFF);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 2'b01, 10'd6, 18'h00000);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 2'b10, 10'd6, 18'h3FE55);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 2'b11, 10'd6, 18'h12345);
        tick();
        idle_both();
        set_b(1'b0, 1'b1, 1'b1, 2'b00, 10'd6, '0);
        tick();
        check("R2 lane-masked result", b_rdata, 18'h00055);
        idle_both();
        tick();
    endtask

    // Output enable and lane gating on reads (R3)
    task automatic t_oe();
        a_oe_n = 1'b1;
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R3 oe high no drive", {16'h0, a_drive}, '0);
        check("R3 oe high data zero", a_rdata, '0);
        #2 a_oe_n = 1'b0;
        #1;
        check("R3 async oe drive", {16'h0, a_drive}, 18'd3);
        check("R3 async oe data", a_rdata, V5);
        set_a(1'b0, 1'b1, 1'b1, 2'b10, 10'd5, '0);
        tick();
        check("R3 lower lane only", a_rdata, V5 & LO);
        idle_both();
        tick();
    endtask

    // Select decode and flow-through deselect timing (R1, R6)
    task automatic t_flow_desel();
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        set_a(1'b1, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R6 flow deselect immediate", {16'h0, a_drive}, '0);
        set_a(1'b0, 1'b0, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R1 cs1 low read quiet", {16'h0, a_drive}, '0);
        set_a(1'b0, 1'b0, 1'b0, 2'b00, 10'd5, 18'h00000);
        tick();
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R1 deselected write ignored", a_rdata, V5);
        idle_both();
        tick();
    endtask

    // Pipelined latency, deselect lag, lane stage, write suppress (R5, R6, R7, R8)
    task automatic t_pipe();
        a_pipe = 1'b1;
        tick();
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R5 pipe not in own cycle", {16'h0, a_drive}, '0);
        set_a(1'b1, 1'b1, 1'b1, 2'b00, 10'd0, '0);
        tick();
        check("R5 pipe data next cycle", a_rdata, V5);
        check("R6 pipe drives after deselect", {16'h0, a_drive}, 18'd3);
        tick();
        check("R6 pipe quiet two cycles on", {16'h0, a_drive}, '0);
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        set_a(1'b1, 1'b1, 1'b1, 2'b10, 10'd0, '0);
        tick();
        check("R7 pipe lanes from latest edge", {16'h0, a_drive}, 18'd1);
        check("R7 pipe lower data", a_rdata, V5 & LO);
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 2'b00, 10'd7, 18'h0F0F0);
        tick();
        check("R8 pipe read hidden by write", {16'h0, a_drive}, '0);
        idle_both();
        tick();
        tick();
        a_pipe = 1'b0;
        tick();
    endtask

    // Same-edge write/read collision returns old data (R9)
    task automatic t_read_old();
        set_a(1'b0, 1'b1, 1'b0, 2'b00, 10'd9, 18'h11111);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 2'b00, 10'd9, 18'h22222);
        set_b(1'b0, 1'b1, 1'b1, 2'b00, 10'd9, '0);
        tick();
        check("R9 collision returns old", b_rdata, 18'h11111);
        set_a(1'b1, 1'b1, 1'b1, 2'b00, 10'd0, '0);
        tick();
        check("R9 new value next cycle", b_rdata, 18'h22222);
        idle_both();
        tick();
    endtask

    // Write-write collision: port A wins per lane (R10)
    task automatic t_write_write();
        set_a(1'b0, 1'b1, 1'b0, 2'b00, 10'd10, 18'h0ABCD);
        set_b(1'b0, 1'b1, 1'b0, 2'b00, 10'd10, 18'h3F00F);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 2'b01, 10'd11, 18'h3FE00);
        set_b(1'b0, 1'b1, 1'b0, 2'b00, 10'd11, 18'h00000);
        tick();
        idle_both();
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd10, '0);
        tick();
        check("R10 A wins full word", a_rdata, 18'h0ABCD);
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd11, '0);
        tick();
        check("R10 A wins upper, B keeps lower", a_rdata, 18'h3FE00);
        idle_both();
        tick();
    endtask

    // Both ports read the same word (R12)
    task automatic t_dual_read();
        set_a(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        set_b(1'b0, 1'b1, 1'b1, 2'b00, 10'd5, '0);
        tick();
        check("R12 port A shared read", a_rdata, V5);
        check("R12 port B shared read", b_rdata, V5);
        check("R12 both drive", {14'h0, a_drive, 2'b00} | {16'h0, b_drive}, 18'hF);
        idle_both();
        tick();
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_flow_basic();
        t_lanes();
        t_oe();
        t_flow_desel();
        t_pipe();
        t_read_old();
        t_write_write();
        t_dual_read();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule